// File: doc/BRIEF.md
# Quarter-Rate IF Pulse-Shaping Modulator

This block turns a stream of complex chips into a single real sample stream at four samples per chip. Each chip passes through a four-phase polyphase root-raised-cosine interpolator (roll-off 0.22, span of 12 chips, 48 taps at the oversampled rate). The result is then placed on a digital carrier at one quarter of the sample rate. The carrier step needs no multiplier and no oscillator: each output sample takes either the I branch or the Q branch of the interpolator, and its sign follows a four-step cycle.

When the sample rate is picked so that the intermediate frequency equals (l + 1/4) times the sample rate for some positive integer l, one spectral image of this stream lands on the IF. A single D/A converter followed by a band-pass filter can then drive the IF stage directly.

The sample clock is a one-cycle enable, `smp_en`. Chips arrive over a valid/ready handshake, and the block takes at most one chip per group of four enables. The coefficients are a fixed table that is computed at elaboration.

Top module: `qif_modulator`

## Requirements
- R1: While `rst` is high, and after it falls, `out_valid` is 0, `out_sample` is 0, the slot count is 0 and all 12 chip taps hold zero.
- R2: `chip_ready` is high only in a cycle where `smp_en` is high and that enable is slot 0, meaning its index counted from reset, mod 4, is 0. It is low in every other cycle.
- R3: At a slot-0 enable, the pair (`chip_i`, `chip_q`) enters the newest tap when `chip_valid` is high. When `chip_valid` is low, a zero chip enters instead. `chip_valid` and the chip data have no effect on any output at any other time.
- R4: Each `smp_en` produces exactly one output. `out_valid` is high for the single cycle after the enable, and `out_sample` keeps its value in cycles that follow no enable.
- R5: For slot s, the pre-rotation sum is the sum over k = 0..11 of h[4k+s]·x[k]. Here x[k] is the chip k positions older than the newest one (tap 0), including the chip accepted at this enable. The coefficients are h[m] = round-half-away(16384·g((m−23.5)/4)), with g(t) = [sin(πt·0.78) + 0.88t·cos(πt·1.22)] / [πt·(1 − (0.88t)²)].
- R6: The slot selects the branch and the sign. Slot 0 gives +I, slot 1 gives −Q, slot 2 gives −I and slot 3 gives +Q. Even slots take the I taps and odd slots take the Q taps.
- R7: The signed sum v becomes floor((v + 8192) / 16384). That value is clipped to the signed 8-bit range [−128, 127] and never wraps.
- R8: The first enable after reset yields the slot-0 sample. At that point tap 0 holds the chip just accepted and every older tap is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle sample-rate enable |
| chip_valid | input | 1 | Chip offered |
| chip_ready | output | 1 | Chip taken this cycle (slot-0 enable) |
| chip_i | input | 8 | In-phase chip value, signed |
| chip_q | input | 8 | Quadrature chip value, signed |
| out_valid | output | 1 | New output sample, one cycle after the enable |
| out_sample | output | 8 | Real IF sample, signed, registered |

## Verification
A slot count that is out of step rotates the signs wrongly and reads the wrong coefficient phase. It also moves the ready pulse, so the first sample after reset already disagrees with the model on value, and the handshake check catches it within four enables. A tap line that shifts too often, or that takes chips offered outside slot 0, changes the impulse response sample by sample. An impulse on each branch exposes all 48 coefficients and both sign patterns within 12 chip groups. Faults in rounding or clipping show up on full-scale sign-matched chip patterns, where a wrapped sum flips the sign of the output.

// File: rtl/qif_pkg.sv
package qif_pkg;

  localparam int unsigned OVS   = 4;
  localparam int unsigned ROT_W = $clog2(OVS);
  localparam real         PI    = 3.14159265358979;

  typedef logic [ROT_W-1:0] rot_t;

  // root-raised-cosine tap m of ntap, scaled by 2**frac, rounded half away from zero
  function automatic int rrc_coef(input int m, input int ntap, input real beta, input int frac);
    real t, num, den, v;
    t   = (real'(m) - real'(ntap - 1) / 2.0) / real'(OVS);
    num = $sin(PI * t * (1.0 - beta)) + 4.0 * beta * t * $cos(PI * t * (1.0 + beta));
    den = PI * t * (1.0 - (4.0 * beta * t) * (4.0 * beta * t));
    v   = num / den * real'(1 << frac);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/qif_phase_ctrl.sv
module qif_phase_ctrl (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  output qif_pkg::rot_t rot,
  output logic          load
);

  always_ff @(posedge clk) begin
    if (rst)         rot <= '0;
    else if (smp_en) rot <= qif_pkg::rot_t'(rot + 1'b1);
  end

  assign load = smp_en && (rot == '0);

  AST_ROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(rot)); // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R2

endmodule

// File: rtl/qif_tap_line.sv
module qif_tap_line #(
  parameter int CHIP_W = 8,
  parameter int SPAN   = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [CHIP_W-1:0] in_i,
  input  logic signed [CHIP_W-1:0] in_q,
  output logic signed [CHIP_W-1:0] nxt_i [SPAN],
  output logic signed [CHIP_W-1:0] nxt_q [SPAN]
);

  logic signed [CHIP_W-1:0] ti [SPAN];
  logic signed [CHIP_W-1:0] tq [SPAN];

  for (genvar k = 0; k < SPAN; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign nxt_i[k] = load ? in_i : ti[k];
      assign nxt_q[k] = load ? in_q : tq[k];
    end else begin : g_body
      assign nxt_i[k] = load ? ti[k-1] : ti[k];
      assign nxt_q[k] = load ? tq[k-1] : tq[k];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ti[k] <= '0;
        tq[k] <= '0;
      end else begin
        ti[k] <= nxt_i[k];
        tq[k] <= nxt_q[k];
      end
    end
  end

  AST_TAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    load |=> (ti[0] == $past(in_i)) && (tq[0] == $past(in_q))); // R3
  AST_TAP_AGE: assert property (@(posedge clk) disable iff (rst)
    load |=> (ti[SPAN-1] == $past(ti[SPAN-2]))); // R5
  AST_TAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ti[0]) && $stable(tq[0])); // R3

endmodule

// File: rtl/qif_poly_mac.sv
module qif_poly_mac #(
  parameter int  CHIP_W    = 8,
  parameter int  COEF_W    = 16,
  parameter int  COEF_FRAC = 14,
  parameter int  SPAN      = 12,
  parameter real BETA      = 0.22,
  parameter int  ACC_W     = 30
) (
  input  qif_pkg::rot_t            rot,
  input  logic signed [CHIP_W-1:0] taps [SPAN],
  output logic signed [ACC_W-1:0]  acc
);

  localparam int NTAP = SPAN * qif_pkg::OVS;

  logic signed [ACC_W-1:0] prod [SPAN];

  for (genvar k = 0; k < SPAN; k++) begin : g_tap
    logic signed [COEF_W-1:0] cph [qif_pkg::OVS];
    for (genvar p = 0; p < qif_pkg::OVS; p++) begin : g_ph
      localparam logic signed [COEF_W-1:0] C =
        COEF_W'(qif_pkg::rrc_coef(k * qif_pkg::OVS + p, NTAP, BETA, COEF_FRAC));
      assign cph[p] = C;
    end
    assign prod[k] = ACC_W'(taps[k]) * ACC_W'(cph[rot]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < SPAN; k++) acc = acc + prod[k];
  end

endmodule

// File: rtl/qif_round_sat.sv
module qif_round_sat #(
  parameter int ACC_W = 30,
  parameter int FRAC  = 14,
  parameter int OUT_W = 8
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    neg,
  output logic signed [OUT_W-1:0] y
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC - 1));
  localparam logic signed [ACC_W-1:0] YMAX = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] YMIN = ACC_W'(-(2 ** (OUT_W - 1)));

  logic signed [ACC_W-1:0] v;
  logic signed [ACC_W-1:0] r;

  always_comb begin
    v = neg ? -acc : acc;
    r = (v + HALF) >>> FRAC;
    if (r > YMAX)      y = YMAX[OUT_W-1:0];
    else if (r < YMIN) y = YMIN[OUT_W-1:0];
    else               y = r[OUT_W-1:0];
  end

endmodule

// File: rtl/qif_modulator.sv
module qif_modulator #(
  parameter int  CHIP_W    = 8,
  parameter int  COEF_W    = 16,
  parameter int  COEF_FRAC = 14,
  parameter int  OUT_W     = 8,
  parameter int  SPAN      = 12,
  parameter real BETA      = 0.22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_en,
  input  logic                     chip_valid,
  output logic                     chip_ready,
  input  logic signed [CHIP_W-1:0] chip_i,
  input  logic signed [CHIP_W-1:0] chip_q,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);

  localparam int ACC_W = CHIP_W + COEF_W + $clog2(SPAN) + 2;

  qif_pkg::rot_t            rot;
  logic                     load;
  logic signed [CHIP_W-1:0] in_i, in_q;
  logic signed [CHIP_W-1:0] nxt_i [SPAN];
  logic signed [CHIP_W-1:0] nxt_q [SPAN];
  logic signed [CHIP_W-1:0] sel   [SPAN];
  logic signed [ACC_W-1:0]  acc;
  logic                     neg;
  logic signed [OUT_W-1:0]  y;

  qif_phase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .smp_en(smp_en), .rot(rot), .load(load)
  );

  assign chip_ready = load;
  assign in_i = chip_valid ? chip_i : '0;
  assign in_q = chip_valid ? chip_q : '0;

  qif_tap_line #(.CHIP_W(CHIP_W), .SPAN(SPAN)) u_taps (
    .clk(clk), .rst(rst), .load(load), .in_i(in_i), .in_q(in_q),
    .nxt_i(nxt_i), .nxt_q(nxt_q)
  );

  // odd slots read the quadrature branch, even slots the in-phase branch
  for (genvar k = 0; k < SPAN; k++) begin : g_sel
    assign sel[k] = rot[0] ? nxt_q[k] : nxt_i[k];
  end

  qif_poly_mac #(
    .CHIP_W(CHIP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .SPAN(SPAN), .BETA(BETA), .ACC_W(ACC_W)
  ) u_mac (
    .rot(rot), .taps(sel), .acc(acc)
  );

  // slots 1 and 2 carry a negative sign
  assign neg = rot[0] ^ rot[1];

  qif_round_sat #(.ACC_W(ACC_W), .FRAC(COEF_FRAC), .OUT_W(OUT_W)) u_rsat (
    .acc(acc), .neg(neg), .y(y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= smp_en;
      if (smp_en) out_sample <= y;
    end
  end

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> out_valid); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> !out_valid && $stable(out_sample)); // R4
  AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
    chip_ready |-> smp_en); // R2

endmodule

// File: tb/qif_modulator_tb.sv
module qif_modulator_tb;

  localparam int SPAN = 12;
  localparam int NT   = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic chip_valid = 1'b0;
  logic signed [7:0] chip_i = '0;
  logic signed [7:0] chip_q = '0;
  logic chip_ready, out_valid;
  logic signed [7:0] out_sample;

  qif_modulator u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .chip_valid(chip_valid),
    .chip_ready(chip_ready), .chip_i(chip_i), .chip_q(chip_q),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  always #10 clk = ~clk;

  int hb [NT];
  int hi [SPAN];
  int hq [SPAN];
  int bs;
  int exp_q [$];
  int n_chk, n_fail, sat_seen, last, e;
  bit done, first;

  function automatic int bench_coef(int m);
    real t, a, b, v;
    real pi = 3.14159265358979;
    t = (real'(m) - 23.5) / 4.0;
    a = $sin(pi * t * 0.78) + 0.88 * t * $cos(pi * t * 1.22);
    b = pi * t * (1.0 - (0.88 * t) * (0.88 * t));
    v = 16384.0 * a / b;
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic int model_out(int p);
    longint acc = 0;
    for (int k = 0; k < SPAN; k++)
      acc += longint'(hb[4*k+p]) * longint'((p % 2 == 0) ? hi[k] : hq[k]);
    if (p == 1 || p == 2) acc = -acc;
    acc = (acc + 8192) >>> 14;
    if (acc > 127)  begin sat_seen++; return 127;  end
    if (acc < -128) begin sat_seen++; return -128; end
    return int'(acc);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < SPAN; k++) begin hi[k] = 0; hq[k] = 0; end
    bs = 0;
  endtask

  // one enable; pushes the expected sample into the scoreboard
  task automatic step(bit v, int di, int dq);
    @(negedge clk);
    smp_en = 1'b1; chip_valid = v; chip_i = 8'(di); chip_q = 8'(dq);
    #1;
    check(chip_ready == (bs == 0), "R2 ready on slot 0 only", int'(chip_ready), int'(bs == 0));
    if (bs == 0) begin
      for (int k = SPAN - 1; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
      hi[0] = v ? di : 0;
      hq[0] = v ? dq : 0;
    end
    exp_q.push_back(model_out(bs));
    bs = (bs + 1) % 4;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      smp_en = 1'b0; chip_valid = 1'b1; chip_i = 8'sd99; chip_q = -8'sd77;
      #1;
      check(chip_ready == 1'b0, "R2 ready low without enable", int'(chip_ready), 0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R4 output without enable", int'(out_sample), 0);
        else begin
          e = exp_q.pop_front();
          check(out_sample == 8'(e), first ? "R8 first sample after reset" : "R5 R6 R7 sample",
                int'(out_sample), e);
          first = 1'b0;
        end
        last = int'(out_sample);
      end else begin
        check(int'(out_sample) == last, "R4 hold between enables", int'(out_sample), last);
      end
    end
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int m = 0; m < NT; m++) hb[m] = bench_coef(m);
    model_clear();
    first = 1'b1;
    last = 0;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    check(out_sample == 0, "R1 reset out_sample", int'(out_sample), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(chip_ready == 1'b0, "R1 ready idle after reset", int'(chip_ready), 0);

    // in-phase impulse; junk offered on slots 1..3 must be ignored (R3)
    step(1, 100, 0);
    step(1, 55, -33); step(1, -20, 70); step(1, 127, 127);
    for (int g = 0; g < 14; g++) for (int s = 0; s < 4; s++) step(1, 0, 0);

    // quadrature impulse with idle cycles between enables
    step(1, 0, -90);
    idle(2);
    for (int g = 0; g < 14 * 4 - 1; g++) begin
      step(g % 4 == 3, 0, 0);
      idle(g % 3);
    end

    // QPSK-like random chips, some groups with no chip offered (R3 underflow)
    for (int g = 0; g < 60; g++) begin
      for (int s = 0; s < 4; s++) begin
        step(($urandom % 5) != 0, ($urandom % 2) ? 90 : -90, ($urandom % 2) ? 90 : -90);
        idle($urandom % 3);
      end
    end
    idle(3);

    // mid-stream reset (R1); following output again starts at slot 0 (R8)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset mid-stream out_valid", int'(out_valid), 0);
    check(out_sample == 0, "R1 reset mid-stream out_sample", int'(out_sample), 0);
    exp_q.delete();
    model_clear();
    last = 0;
    first = 1'b1;
    @(negedge clk);
    rst = 1'b0;

    // chips without chip_valid only: the output stays at zero (R3)
    for (int g = 0; g < 8; g++) for (int s = 0; s < 4; s++) step(0, 127, -128);

    // full-scale chips matched to coefficient signs force clipping (R7)
    for (int j = 0; j < SPAN; j++) begin
      step(1, (hb[4*(SPAN-1-j)] >= 0) ? 127 : -128, (hb[4*(SPAN-1-j)+1] >= 0) ? -128 : 127);
      step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    end
    for (int g = 0; g < 40; g++) begin
      step(1, ($urandom % 2) ? 127 : -128, ($urandom % 2) ? 127 : -128);
      step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    end
    idle(4);

    check(exp_q.size() == 0, "R4 every enable produced one sample", exp_q.size(), 0);
    check(sat_seen > 0, "R7 clipping exercised", sat_seen, 1);
    finish_run();
  end

endmodule